// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Operand Bypass Control

This block is the hazard controller for a five-stage in-order integer pipeline with fetch, decode, execute, memory and write-back stages. It compares the two source register numbers of the instruction in decode with the destination fields of the older instructions in execute, memory and write-back. From that comparison it drives the operand source selects, a stall that holds the PC and the fetch/decode register, a bubble strobe for the decode/execute register, and a flush that kills the wrong-path fetch after a taken branch. The datapath multiplexers, the register file, the ALU and the branch comparator sit outside the block.

Execute-stage bypass selects are worked out while the consumer is still in decode. They are then captured in the block's own register, so they line up with the consumer once it reaches execute. When a stall inserts a bubble, that register is cleared. Branches resolve in decode and fetch assumes not-taken, so a taken branch costs one squashed fetch slot. A branch whose operand is still being computed in execute, or is being loaded in memory, waits in decode. A branch whose operand comes from a non-load instruction in memory takes that value through a decode-stage bypass. The register file is assumed not to forward a same-cycle write to a read. Because of that, the write-back result is also offered to decode. A parameter removes this path for register files that do write-through.

Top module: `hazard_ctl`

## Requirements
- R1: When the instruction in execute is a load (ex_wen=1, ex_load=1) with a nonzero ex_rd equal to id_rs1 or id_rs2, stall and bubble are 1 in that same cycle.
- R2: When ex_wen=1, ex_load=0 and a nonzero ex_rd equals a decode source, and there is no stall, that source's execute select reads 2 (memory-stage result) one clock later.
- R3: When mem_wen=1 and a nonzero mem_rd equals a decode source, with no execute match and no stall, that source's execute select reads 1 (write-back result) one clock later. This holds for loads and for ALU results.
- R4: When execute and memory both match a source, the execute-stage producer wins: the select one clock later is 2, not 1.
- R5: Register 0 never causes a stall. It never yields a nonzero decode select or execute select, whatever the stage fields hold.
- R6: A branch in decode (id_branch=1) stalls when either source matches a writing instruction in execute, or a load in memory.
- R7: A branch whose source matches a non-load writer in memory does not stall. Its decode select for that source is 1 (memory-stage bypass).
- R8: When wb_wen=1 and a nonzero wb_rd matches a decode source, that decode select is 2 (write-back bypass). For a branch that also matches a non-load writer in memory, the memory value wins and the select is 1.
- R9: flush is 1 only when id_branch=1, id_br_taken=1 and no stall is raised. A stall overrides a flush.
- R10: In a cycle with stall=1, both execute selects read 0 (pipeline register value) one clock later. This is the bubble with all control cleared.
- R11: With no matching producer, stall, bubble and flush are 0 and every select is 0. While rst_n is low, both execute selects are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | REG_W | First source register of the instruction in decode |
| id_rs2 | input | REG_W | Second source register of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_br_taken | input | 1 | Decode comparator outcome: branch taken |
| ex_rd | input | REG_W | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_W | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_load | input | 1 | Instruction in memory is a load |
| wb_rd | input | REG_W | Destination of the instruction in write-back |
| wb_wen | input | 1 | Instruction in write-back writes a register |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load an empty slot into decode/execute |
| flush | output | 1 | Squash the wrong-path fetch |
| id_sel_a | output | 2 | Decode operand A source: 0 file, 1 memory stage, 2 write-back |
| id_sel_b | output | 2 | Decode operand B source: 0 file, 1 memory stage, 2 write-back |
| ex_sel_a | output | 2 | Execute operand A source: 0 pipeline reg, 1 write-back, 2 memory stage |
| ex_sel_b | output | 2 | Execute operand B source: 0 pipeline reg, 1 write-back, 2 memory stage |

## Verification
The stall and the flush can both be called for in one cycle. This happens when a taken branch in decode waits on a producer in execute or on a load in memory. The bench sets up exactly that case, with id_br_taken high and the dependence present together. It expects stall high and flush low in that cycle. One clock later both execute selects must read zero. A second vector removes the dependence by moving the producer to a non-load in memory. There the flush must appear, together with a memory-stage decode select.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      IDS_RF  = 2'd0,
      IDS_MEM = 2'd1,
      IDS_WB  = 2'd2
   } id_src_e;

   typedef enum logic [1:0] {
      EXS_PIPE = 2'd0,
      EXS_WB   = 2'd1,
      EXS_MEM  = 2'd2
   } ex_src_e;
endpackage

// File: rtl/hz_src_path.sv
module hz_src_path
   import hz_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit WRITE_THRU = 1'b0
) (
   input  logic [REG_W-1:0] src,
   input  logic             is_branch,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_load,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic             load_use,
   output logic             br_hold,
   output id_src_e          id_sel,
   output ex_src_e          ex_nxt
);
   logic live, ex_hit, mem_hit;

   assign live    = (src != '0);
   assign ex_hit  = live && ex_wen  && (ex_rd  == src);
   assign mem_hit = live && mem_wen && (mem_rd == src);

   assign load_use = ex_hit && ex_load;
   assign br_hold  = is_branch && (ex_hit || (mem_hit && mem_load));

   always_comb begin
      if (ex_hit)       ex_nxt = EXS_MEM;
      else if (mem_hit) ex_nxt = EXS_WB;
      else              ex_nxt = EXS_PIPE;
   end

   generate
      if (WRITE_THRU) begin : g_rf_thru
         always_comb begin
            if (is_branch && mem_hit && !mem_load) id_sel = IDS_MEM;
            else                                   id_sel = IDS_RF;
         end
      end else begin : g_wb_byp
         logic wb_hit;
         assign wb_hit = live && wb_wen && (wb_rd == src);
         always_comb begin
            if (is_branch && mem_hit && !mem_load) id_sel = IDS_MEM;
            else if (wb_hit)                       id_sel = IDS_WB;
            else                                   id_sel = IDS_RF;
         end
      end
   endgenerate
endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg
   import hz_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    clear,
   input  ex_src_e d,
   output ex_src_e q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= EXS_PIPE;
      else if (clear) q <= EXS_PIPE;
      else            q <= d;
   end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
   import hz_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter bit WRITE_THRU = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] id_rs1,
   input  logic [REG_W-1:0] id_rs2,
   input  logic             id_branch,
   input  logic             id_br_taken,
   input  logic [REG_W-1:0] ex_rd,
   input  logic             ex_wen,
   input  logic             ex_load,
   input  logic [REG_W-1:0] mem_rd,
   input  logic             mem_wen,
   input  logic             mem_load,
   input  logic [REG_W-1:0] wb_rd,
   input  logic             wb_wen,
   output logic             stall,
   output logic             bubble,
   output logic             flush,
   output logic [1:0]       id_sel_a,
   output logic [1:0]       id_sel_b,
   output logic [1:0]       ex_sel_a,
   output logic [1:0]       ex_sel_b
);
   localparam int NSRC = 2;

   generate
      if (REG_W < 2 || REG_W > 8) begin : g_bad_width
         $error("hazard_ctl: REG_W out of range");
      end
   endgenerate

   logic [REG_W-1:0] src_v    [NSRC];
   logic [NSRC-1:0]  lu_v;
   logic [NSRC-1:0]  bh_v;
   id_src_e          id_sel_v [NSRC];
   ex_src_e          ex_nxt_v [NSRC];
   ex_src_e          ex_q_v   [NSRC];

   assign src_v[0] = id_rs1;
   assign src_v[1] = id_rs2;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         hz_src_path #(.REG_W(REG_W), .WRITE_THRU(WRITE_THRU)) path_i (
            .src      (src_v[s]),
            .is_branch(id_branch),
            .ex_rd    (ex_rd),
            .ex_wen   (ex_wen),
            .ex_load  (ex_load),
            .mem_rd   (mem_rd),
            .mem_wen  (mem_wen),
            .mem_load (mem_load),
            .wb_rd    (wb_rd),
            .wb_wen   (wb_wen),
            .load_use (lu_v[s]),
            .br_hold  (bh_v[s]),
            .id_sel   (id_sel_v[s]),
            .ex_nxt   (ex_nxt_v[s])
         );
         hz_sel_reg sel_i (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(stall),
            .d    (ex_nxt_v[s]),
            .q    (ex_q_v[s])
         );
      end
   endgenerate

   assign stall    = (|lu_v) || (|bh_v);
   assign bubble   = stall;
   assign flush    = id_branch && id_br_taken && !stall;
   assign id_sel_a = id_sel_v[0];
   assign id_sel_b = id_sel_v[1];
   assign ex_sel_a = ex_q_v[0];
   assign ex_sel_b = ex_q_v[1];
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
   parameter int REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] id_rs1,
   input logic [REG_W-1:0] id_rs2,
   input logic             id_branch,
   input logic             id_br_taken,
   input logic [REG_W-1:0] ex_rd,
   input logic             ex_wen,
   input logic             ex_load,
   input logic             stall,
   input logic             bubble,
   input logic             flush,
   input logic [1:0]       id_sel_a,
   input logic [1:0]       ex_sel_a,
   input logic [1:0]       ex_sel_b
);
   // R1
   load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load && ex_wen && ex_rd != '0 && ex_rd == id_rs1) |-> (stall && bubble));

   // R10
   bubble_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0));

   // R5
   zero_src_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs1 == '0) |=> (ex_sel_a == 2'd0));

   // R5
   zero_src_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_rs1 == '0) |-> (id_sel_a == 2'd0));

   // R9
   flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (id_branch && id_br_taken && !stall));

   // R2
   ex_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall && ex_wen && !ex_load && ex_rd != '0 && ex_rd == id_rs2) |=> (ex_sel_b == 2'd2));
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .id_rs1     (id_rs1),
   .id_rs2     (id_rs2),
   .id_branch  (id_branch),
   .id_br_taken(id_br_taken),
   .ex_rd      (ex_rd),
   .ex_wen     (ex_wen),
   .ex_load    (ex_load),
   .stall      (stall),
   .bubble     (bubble),
   .flush      (flush),
   .id_sel_a   (id_sel_a),
   .ex_sel_a   (ex_sel_a),
   .ex_sel_b   (ex_sel_b)
);

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb_top;
   localparam int RW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
   logic          id_branch = 1'b0, id_br_taken = 1'b0;
   logic          ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, mem_load = 1'b0, wb_wen = 1'b0;
   logic          stall, bubble, flush;
   logic [1:0]    id_sel_a, id_sel_b, ex_sel_a, ex_sel_b;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   hazard_ctl #(.REG_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .id_branch(id_branch), .id_br_taken(id_br_taken),
      .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
      .wb_rd(wb_rd), .wb_wen(wb_wen),
      .stall(stall), .bubble(bubble), .flush(flush),
      .id_sel_a(id_sel_a), .id_sel_b(id_sel_b),
      .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b)
   );

   typedef struct packed {
      logic [4:0] rs1;
      logic [4:0] rs2;
      logic       br;
      logic       tk;
      logic [4:0] exrd;
      logic       exw;
      logic       exl;
      logic [4:0] mrd;
      logic       mw;
      logic       ml;
      logic [4:0] wrd;
      logic       ww;
      logic       e_stall;
      logic       e_flush;
      logic [1:0] e_ida;
      logic [1:0] e_idb;
      logic [1:0] e_exa;
      logic [1:0] e_exb;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 15;
   //  rs1  rs2  br tk exrd w l  mrd  w l  wrd  w  st fl ida idb exa exb req
   localparam vec_t VT [NV] = '{
      '{5'd1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd11}, // R11 idle
      '{5'd1, 5'd2, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0, 4'd2},  // R2 on A
      '{5'd1, 5'd2, 1'b0, 1'b0, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 4'd2},  // R2 on B
      '{5'd1, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 4'd3},  // R3 ALU in mem
      '{5'd1, 5'd2, 1'b0, 1'b0, 5'd1, 1'b1, 1'b0, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 2'd0, 4'd4},  // R4 newer wins
      '{5'd4, 5'd3, 1'b0, 1'b0, 5'd3, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd1},  // R1 load-use, R10
      '{5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd5},  // R5 reg zero
      '{5'd4, 5'd9, 1'b1, 1'b1, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd9},  // R9 R6 stall beats flush
      '{5'd4, 5'd9, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd6},  // R6 load in mem
      '{5'd4, 5'd5, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 2'd0, 4'd7},  // R7 mem bypass, flush
      '{5'd6, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd6, 1'b1, 1'b0, 1'b0, 2'd2, 2'd0, 2'd0, 2'd0, 4'd8},  // R8 wb bypass
      '{5'd1, 5'd7, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 2'd1, 4'd8},  // R8 mem over wb
      '{5'd1, 5'd2, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd9},  // R9 not taken
      '{5'd6, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd6, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 4'd8},  // R8 no enable
      '{5'd8, 5'd2, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 4'd3}   // R3 load in mem
   };

   task automatic chk(input string what, input int req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      id_rs1 = v.rs1; id_rs2 = v.rs2; id_branch = v.br; id_br_taken = v.tk;
      ex_rd = v.exrd; ex_wen = v.exw; ex_load = v.exl;
      mem_rd = v.mrd; mem_wen = v.mw; mem_load = v.ml;
      wb_rd = v.wrd; wb_wen = v.ww;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL R11 watchdog: actual 0 expected 1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      // R11: reset state
      repeat (2) @(negedge clk);
      chk("ex_sel_a in reset", 11, ex_sel_a, 0);
      chk("ex_sel_b in reset", 11, ex_sel_b, 0);
      chk("stall at idle", 11, stall, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VT[i]);
         #1;
         chk("stall",    VT[i].req, stall,    VT[i].e_stall);
         chk("bubble",   VT[i].req, bubble,   VT[i].e_stall);
         chk("flush",    VT[i].req, flush,    VT[i].e_flush);
         chk("id_sel_a", VT[i].req, id_sel_a, VT[i].e_ida);
         chk("id_sel_b", VT[i].req, id_sel_b, VT[i].e_idb);
         @(posedge clk);
         #1;
         chk("ex_sel_a", VT[i].req, ex_sel_a, VT[i].e_exa);
         chk("ex_sel_b", VT[i].req, ex_sel_b, VT[i].e_exb);
      end

      // R10: load-use followed by the resolved cycle, load now in memory
      @(negedge clk);
      drive(VT[5]);
      @(posedge clk); #1;
      chk("bubble select A", 10, ex_sel_a, 0);
      chk("bubble select B", 10, ex_sel_b, 0);
      @(negedge clk);
      ex_wen = 1'b0; ex_load = 1'b0; ex_rd = '0;
      mem_rd = 5'd3; mem_wen = 1'b1; mem_load = 1'b1;
      #1;
      chk("stall after bubble", 1, stall, 0);
      @(posedge clk); #1;
      chk("loaded value to B", 3, ex_sel_b, 1);

      // R11: asynchronous reset clears a live select
      @(negedge clk);
      drive(VT[1]);
      @(posedge clk); #1;
      chk("select before reset", 2, ex_sel_a, 2);
      rst_n = 1'b0;
      #1;
      chk("select cleared by reset", 11, ex_sel_a, 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule